// File: doc/BRIEF.md
# Serial Flash Clock and Chip-Select Timing Generator

This block produces the serial clock and the chip-select lines for a serial flash master, together with the guard intervals around each select window. It runs entirely from the reference clock. The serial clock is the reference clock divided by an even ratio, 2*(N+1), where N is a 4-bit divisor field. Its rest level and the meaning of its edges follow the usual polarity and phase settings. Four 8-bit guard delays, counted in reference cycles, set four intervals: from chip select falling to the first clock edge, from the last clock edge to chip select rising, the minimum high time between any two windows, and a separate minimum that applies when consecutive windows select different devices.

A shift engine holds `xfer_req` high to ask for a window and gives the number of clock periods on `xfer_len`. The block accepts the request only when it is idle and the guard time has elapsed. It then latches the device selection, asserts chip select, generates the clock edges, deasserts chip select and pulses `xfer_done`. The block emits one-cycle strobes, `smp_stb` and `shf_stb`, on the cycle of each clock edge. These tell the shift engine when to capture data and when to launch it. Chip selects are either one-hot active-low, with the field's low bits as the device index, or the raw 4-bit field for an external decoder. The timing configuration may be changed only while `cfg_en` is low.

Top module: `spi_cs_timing_gen`

## Requirements
- R1: While `cfg_en` is low or no window is open, `cs_n` is 4'b1111, `sclk` equals `cfg_cpol` and `xfer_busy` is low. A request made while disabled is ignored. Dropping `cfg_en` during a window closes it: in the next cycle `cs_n` is 4'b1111, `sclk` is back at `cfg_cpol` and `xfer_done` pulses.
- R2: Consecutive serial clock edges inside a window are `cfg_baud`+1 reference cycles apart, so one clock period is 2*(`cfg_baud`+1) cycles.
- R3: The first clock edge appears `dly_setup`+1 cycles after the first cycle in which chip select is asserted.
- R4: Chip select returns to 4'b1111 `dly_hold`+1 cycles after the last clock edge.
- R5: A window carries exactly 2*(`xfer_len`+1) clock edges, and `sclk` ends the window at `cfg_cpol`. The clock never leaves its rest level outside a window.
- R6: With `cfg_dec_en` low, an open window drives `cs_n` to the active-low one-hot code of device `cfg_cs_sel[1:0]`: device 0 gives 1110, 1 gives 1101, 2 gives 1011 and 3 gives 0111.
- R7: With `cfg_dec_en` high, an open window drives `cs_n` to the 4-bit `cfg_cs_sel` value unchanged. Outside a window `cs_n` is 4'b1111.
- R8: Between two windows for the same chip-select code, `cs_n` stays 4'b1111 for at least `dly_gap`+1 cycles. With the request held high, it stays high for exactly that many cycles.
- R9: When the next window's chip-select code differs from the previous one, the minimum high time becomes max(`dly_gap`, `dly_switch`)+1 cycles. A held request waits exactly that long.
- R10: `smp_stb` and `shf_stb` are one-cycle pulses in the cycle where `sclk` changes. With `cfg_cpha` low, `smp_stb` marks leading edges (moving away from `cfg_cpol`) and `shf_stb` marks trailing edges. With `cfg_cpha` high the two roles swap. The two strobes never assert together.
- R11: `xfer_busy` is high exactly while chip select is asserted. `xfer_done` pulses for one cycle, in the first cycle with chip select deasserted.
- R12: The chip-select code is latched when a request is accepted. It stays constant for the whole window even if `cfg_cs_sel` changes meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Global enable |
| cfg_cpol | input | 1 | Clock rest level |
| cfg_cpha | input | 1 | Clock phase: selects which edge samples |
| cfg_baud | input | 4 | Divisor N, half period N+1 cycles |
| cfg_dec_en | input | 1 | 1: encoded select for external decoder |
| cfg_cs_sel | input | 4 | Device index (one-hot mode) or raw code |
| dly_setup | input | 8 | Select-to-first-edge guard |
| dly_hold | input | 8 | Last-edge-to-deselect guard |
| dly_switch | input | 8 | Minimum high time when changing device |
| dly_gap | input | 8 | Minimum high time between windows |
| xfer_req | input | 1 | Window request from shift engine |
| xfer_len | input | 4 | Clock periods in window minus one |
| sclk | output | 1 | Serial clock |
| cs_n | output | 4 | Chip-select lines |
| smp_stb | output | 1 | Capture strobe on the sampling edge |
| shf_stb | output | 1 | Launch strobe on the shifting edge |
| xfer_busy | output | 1 | Window open |
| xfer_done | output | 1 | One-cycle pulse at window close |

## Verification
Some rules hold on every cycle and are checked by the assertions: the rest state of clock and selects outside a window, the one-hot form of the selects, the stability of the select code within a window, the exclusivity and edge alignment of the strobes, the alignment of the done pulse with the window close, and the lower bound on the high time between windows. The exact interval counts cannot be judged from a single cycle, so only the bench scenarios show them. These are the setup and hold guards, the half-period length for every divisor, the number of edges, the exact hold-off for a same-device or a changed-device request, and the behaviour of an abort.

// File: rtl/spi_tg_pkg.sv
// Shared types for the serial clock / chip-select timing generator.
// Assumes: nothing beyond IEEE 1800-2017.
package spi_tg_pkg;

    // Window sequencing: idle, select-to-clock guard, clocking, clock-to-deselect guard
    typedef enum logic [1:0] {
        TG_IDLE  = 2'd0,
        TG_SETUP = 2'd1,
        TG_RUN   = 2'd2,
        TG_HOLD  = 2'd3
    } tg_state_e;

endpackage

// File: rtl/spi_half_div.sv
// Half-period divider: counts reference cycles while run is high and
// pulses tick every div+1 cycles. Assumes run is low in the cycle before
// clocking starts, so the first interval is a full one.
module spi_half_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] hc_q;

    assign tick = run && (hc_q == div);

    // Count up within a half period, restart on tick or when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hc_q <= '0;
        end else if (!run || tick) begin
            hc_q <= '0;
        end else begin
            hc_q <= hc_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_gap_guard.sv
// Guard timer: counts the cycles since chip select was released and
// reports when the required high time has elapsed. Saturates at its
// maximum and comes out of reset saturated, so the first window is not held.
module spi_gap_guard #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_active,
    input  logic [DLY_W-1:0] need,
    output logic             ok
);

    logic [DLY_W-1:0] gcnt_q;

    assign ok = !cs_active && (gcnt_q >= need);

    // Clear while selected, otherwise count up to saturation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcnt_q <= '1;
        end else if (cs_active) begin
            gcnt_q <= '0;
        end else if (gcnt_q != '1) begin
            gcnt_q <= gcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/spi_cs_encode.sv
// Chip-select code builder: either an active-low one-hot code from the
// low index bits, or the raw field for an external decoder.
// Assumes NCS is a power of two, at least 2.
module spi_cs_encode #(
    parameter int NCS = 4
) (
    input  logic           dec_en,
    input  logic [NCS-1:0] sel,
    output logic [NCS-1:0] pat
);

    localparam int SEL_W = $clog2(NCS);

    logic [NCS-1:0] onehot_n;

    // One active-low line per device
    for (genvar i = 0; i < NCS; i++) begin : g_line
        assign onehot_n[i] = (sel[SEL_W-1:0] != SEL_W'(i));
    end

    // Pick encoded or one-hot form
    always_comb begin
        pat = dec_en ? sel : onehot_n;
    end

endmodule

// File: rtl/spi_cs_timing_gen.sv
// Serial clock and chip-select timing generator.
// Opens a select window on request, waits the setup guard, produces
// 2*(xfer_len+1) clock edges at a half period of cfg_baud+1 cycles,
// waits the hold guard, then releases select and enforces the minimum
// high time before the next window. Assumes timing inputs change only
// while cfg_en is low; cfg_cs_sel is latched at acceptance.
module spi_cs_timing_gen
    import spi_tg_pkg::*;
#(
    parameter int NCS   = 4,
    parameter int DIV_W = 4,
    parameter int DLY_W = 8,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic [DIV_W-1:0] cfg_baud,
    input  logic             cfg_dec_en,
    input  logic [NCS-1:0]   cfg_cs_sel,
    input  logic [DLY_W-1:0] dly_setup,
    input  logic [DLY_W-1:0] dly_hold,
    input  logic [DLY_W-1:0] dly_switch,
    input  logic [DLY_W-1:0] dly_gap,
    input  logic             xfer_req,
    input  logic [LEN_W-1:0] xfer_len,
    output logic             sclk,
    output logic [NCS-1:0]   cs_n,
    output logic             smp_stb,
    output logic             shf_stb,
    output logic             xfer_busy,
    output logic             xfer_done
);

    localparam int EDGE_W = LEN_W + 1;

    tg_state_e         state_q;
    logic [DLY_W-1:0]  dcnt_q;
    logic [EDGE_W-1:0] edges_q;
    logic              sclk_q;
    logic              lead_q;
    logic              trail_q;
    logic              done_q;
    logic [NCS-1:0]    cs_pat_q;
    logic [NCS-1:0]    pat_new;
    logic [DLY_W-1:0]  need;
    logic              guard_ok;
    logic              tick;
    logic              busy;

    assign busy = (state_q != TG_IDLE);

    spi_cs_encode #(.NCS(NCS)) u_enc (
        .dec_en (cfg_dec_en),
        .sel    (cfg_cs_sel),
        .pat    (pat_new)
    );

    spi_half_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (cfg_en && (state_q == TG_RUN)),
        .div   (cfg_baud),
        .tick  (tick)
    );

    // Required high time: longer guard applies when the device changes
    always_comb begin
        if ((pat_new != cs_pat_q) && (dly_switch > dly_gap)) begin
            need = dly_switch;
        end else begin
            need = dly_gap;
        end
    end

    spi_gap_guard #(.DLY_W(DLY_W)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_active (busy),
        .need      (need),
        .ok        (guard_ok)
    );

    // Window sequencer, serial clock register and edge strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= TG_IDLE;
            dcnt_q   <= '0;
            edges_q  <= '0;
            sclk_q   <= cfg_cpol;
            lead_q   <= 1'b0;
            trail_q  <= 1'b0;
            done_q   <= 1'b0;
            cs_pat_q <= '1;
        end else begin
            lead_q  <= 1'b0;
            trail_q <= 1'b0;
            done_q  <= 1'b0;
            if (!cfg_en) begin
                state_q <= TG_IDLE;
                sclk_q  <= cfg_cpol;
                dcnt_q  <= '0;
                if (state_q != TG_IDLE) begin
                    done_q <= 1'b1;
                end
            end else begin
                case (state_q)
                    TG_IDLE: begin
                        sclk_q <= cfg_cpol;
                        if (xfer_req && guard_ok) begin
                            state_q  <= TG_SETUP;
                            dcnt_q   <= '0;
                            cs_pat_q <= pat_new;
                            edges_q  <= {xfer_len, 1'b1};
                        end
                    end
                    TG_SETUP: begin
                        if (dcnt_q == dly_setup) begin
                            state_q <= TG_RUN;
                            sclk_q  <= ~sclk_q;
                            lead_q  <= 1'b1;
                        end else begin
                            dcnt_q <= dcnt_q + 1'b1;
                        end
                    end
                    TG_RUN: begin
                        if (tick) begin
                            sclk_q  <= ~sclk_q;
                            lead_q  <= (sclk_q == cfg_cpol);
                            trail_q <= (sclk_q != cfg_cpol);
                            edges_q <= edges_q - 1'b1;
                            if (edges_q == EDGE_W'(1)) begin
                                state_q <= TG_HOLD;
                                dcnt_q  <= '0;
                            end
                        end
                    end
                    TG_HOLD: begin
                        if (dcnt_q == dly_hold) begin
                            state_q <= TG_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            dcnt_q <= dcnt_q + 1'b1;
                        end
                    end
                    default: state_q <= TG_IDLE;
                endcase
            end
        end
    end

    assign sclk      = sclk_q;
    assign cs_n      = busy ? cs_pat_q : '1;
    assign smp_stb   = cfg_cpha ? trail_q : lead_q;
    assign shf_stb   = cfg_cpha ? lead_q : trail_q;
    assign xfer_busy = busy;
    assign xfer_done = done_q;

endmodule

// File: rtl/spi_cs_timing_chk.sv
// Cycle-level rules for the timing generator, bound onto its ports.
// Assumes cfg_cpol changes only while disabled.
module spi_cs_timing_chk #(
    parameter int NCS   = 4,
    parameter int DLY_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_cpol,
    input logic             cfg_dec_en,
    input logic [DLY_W-1:0] dly_gap,
    input logic             sclk,
    input logic [NCS-1:0]   cs_n,
    input logic             smp_stb,
    input logic             shf_stb,
    input logic             xfer_busy,
    input logic             xfer_done
);

    logic [DLY_W:0] hi_cnt;

    // Count the cycles spent with chip select released
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= '1;
        end else if (xfer_busy) begin
            hi_cnt <= '0;
        end else if (hi_cnt != '1) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    AST_IDLE_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_busy && $stable(cfg_cpol)) |-> (cs_n == '1 && sclk == cfg_cpol)); // R1

    AST_SCLK_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((sclk != cfg_cpol) && $stable(cfg_cpol)) |-> xfer_busy); // R5

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && !cfg_dec_en) |-> ($countones(~cs_n) == 1)); // R6

    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_busy) |-> (hi_cnt >= ({1'b0, dly_gap} + 1'b1))); // R8

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_stb && shf_stb)); // R10

    AST_STB_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_stb || shf_stb) |-> (sclk != $past(sclk))); // R10

    AST_DONE_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> $fell(xfer_busy)); // R11

    AST_CS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_busy && $past(xfer_busy)) |-> $stable(cs_n)); // R12

endmodule

bind spi_cs_timing_gen spi_cs_timing_chk #(.NCS(NCS), .DLY_W(DLY_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_cpol   (cfg_cpol),
    .cfg_dec_en (cfg_dec_en),
    .dly_gap    (dly_gap),
    .sclk       (sclk),
    .cs_n       (cs_n),
    .smp_stb    (smp_stb),
    .shf_stb    (shf_stb),
    .xfer_busy  (xfer_busy),
    .xfer_done  (xfer_done)
);

// File: tb/sim_spi_cs_timing_gen.sv
`timescale 1ns/1ps
// Bench: sweeps divisor, modes, guards and device codes; measures every
// interval in reference cycles at the negative edge and compares it with
// counts derived from the requirements.
module sim_spi_cs_timing_gen;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_en, cfg_cpol, cfg_cpha, cfg_dec_en;
    logic [3:0] cfg_baud, cfg_cs_sel, xfer_len;
    logic [7:0] dly_setup, dly_hold, dly_switch, dly_gap;
    logic       xfer_req;
    logic       sclk, smp_stb, shf_stb, xfer_busy, xfer_done;
    logic [3:0] cs_n;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    spi_cs_timing_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_baud(cfg_baud), .cfg_dec_en(cfg_dec_en),
        .cfg_cs_sel(cfg_cs_sel), .dly_setup(dly_setup), .dly_hold(dly_hold),
        .dly_switch(dly_switch), .dly_gap(dly_gap), .xfer_req(xfer_req),
        .xfer_len(xfer_len), .sclk(sclk), .cs_n(cs_n), .smp_stb(smp_stb),
        .shf_stb(shf_stb), .xfer_busy(xfer_busy), .xfer_done(xfer_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    function automatic logic [3:0] pat(input int sel);
        logic [3:0] s = 4'(sel);
        if (cfg_dec_en) return s;
        return ~(4'b0001 << s[1:0]);
    endfunction

    task automatic setcfg(input int b, input bit pol, input bit pha, input bit dec,
                          input int su, input int ho, input int gp, input int sw);
        @(negedge clk);
        cfg_en = 1'b0;
        cfg_baud = 4'(b); cfg_cpol = pol; cfg_cpha = pha; cfg_dec_en = dec;
        dly_setup = 8'(su); dly_hold = 8'(ho); dly_gap = 8'(gp); dly_switch = 8'(sw);
        repeat (2) @(negedge clk);
        cfg_en = 1'b1;
        @(negedge clk);
    endtask

    // One or two windows with the request held; every interval is measured
    task automatic run_pair(input int sa, input int sb, input bit two);
        int n = 0, t_low = 0, t_high = -1, last_e = 0, edges = 0, xf = 0;
        int nx = two ? 2 : 1;
        int stray = 0, csbad = 0, need;
        logic [3:0] pcs = 4'hF, exp_cs;
        logic psclk;
        bit lead, exp_smp;
        need = (pat(sa) != pat(sb) && dly_switch > dly_gap) ? int'(dly_switch) : int'(dly_gap);
        @(negedge clk);
        psclk = sclk;
        cfg_cs_sel = 4'(sa);
        exp_cs = pat(sa);
        xfer_req = 1'b1;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            n++;
            if (pcs == 4'hF && cs_n != 4'hF) begin
                t_low = n; edges = 0;
                chk(cs_n == exp_cs, "R6/R7 select code", cs_n, exp_cs);
                if (xf == 1) chk(t_low - t_high == need + 1, "R8/R9 high time", t_low - t_high, need + 1);
                if (xf == nx - 1) xfer_req = 1'b0;
                else cfg_cs_sel = 4'(sb);   // R12: changed mid-window
            end else if (cs_n != 4'hF && cs_n != exp_cs) begin
                csbad++;
            end
            if (sclk != psclk) begin
                edges++;
                if (edges == 1) chk(n - t_low == int'(dly_setup) + 1, "R3 setup", n - t_low, int'(dly_setup) + 1);
                else chk(n - last_e == int'(cfg_baud) + 1, "R2 half period", n - last_e, int'(cfg_baud) + 1);
                lead = (psclk == cfg_cpol);
                exp_smp = cfg_cpha ? !lead : lead;
                chk(smp_stb == exp_smp && shf_stb == !exp_smp, "R10 strobes",
                    {smp_stb, shf_stb}, {exp_smp, !exp_smp});
                last_e = n;
            end else if (smp_stb || shf_stb) begin
                stray++;
            end
            if (pcs != 4'hF && cs_n == 4'hF) begin
                chk(n - last_e == int'(dly_hold) + 1, "R4 hold", n - last_e, int'(dly_hold) + 1);
                chk(edges == 2 * (int'(xfer_len) + 1), "R5 edge count", edges, 2 * (int'(xfer_len) + 1));
                chk(sclk == cfg_cpol, "R5 end level", sclk, cfg_cpol);
                chk(xfer_done == 1'b1 && !xfer_busy, "R11 done", {xfer_done, xfer_busy}, 2);
                t_high = n; xf++;
                exp_cs = pat(sb);
                if (xf == nx) break;
            end else if (xfer_done) begin
                stray++;
            end
            pcs = cs_n; psclk = sclk;
        end
        xfer_req = 1'b0;
        chk(xf == nx, "R11 windows closed", xf, nx);
        chk(stray == 0, "R10 stray pulses", stray, 0);
        chk(csbad == 0, "R12 code stable", csbad, 0);
        @(negedge clk);
        chk(sclk == cfg_cpol && cs_n == 4'hF && !xfer_busy, "R1 idle", {sclk, cs_n}, {cfg_cpol, 4'hF});
    endtask

    initial begin
        #(4 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        int bad;
        rst_n = 1'b0; cfg_en = 1'b0; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_dec_en = 1'b0;
        cfg_baud = 4'd0; cfg_cs_sel = 4'd0; xfer_len = 4'd0; xfer_req = 1'b0;
        dly_setup = 8'd0; dly_hold = 8'd0; dly_switch = 8'd0; dly_gap = 8'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 4'hF && sclk == 1'b0 && !xfer_busy && !xfer_done, "R1 reset", {cs_n, sclk}, 5'h1E);

        // R1: request while disabled is ignored; abort mid-window
        setcfg(1, 1, 0, 0, 2, 2, 1, 1);
        cfg_en = 1'b0; xfer_len = 4'd3; xfer_req = 1'b1;
        bad = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (cs_n != 4'hF || xfer_busy || sclk != 1'b1) bad++;
        end
        chk(bad == 0, "R1 disabled ignores request", bad, 0);
        cfg_en = 1'b1;
        for (int k = 0; k < 20 && !xfer_busy; k++) @(negedge clk);
        repeat (5) @(negedge clk);
        cfg_en = 1'b0; xfer_req = 1'b0;
        @(negedge clk);
        chk(cs_n == 4'hF && xfer_done && sclk == 1'b1, "R1 abort", {cs_n, xfer_done, sclk}, 6'h3F);
        @(negedge clk);
        chk(!xfer_done && !xfer_busy, "R11 single pulse", xfer_done, 0);

        // Sweep divisor and all four modes with varied guards and lengths
        for (int b = 0; b < 16; b++) begin
            for (int m = 0; m < 4; m++) begin
                setcfg(b, m[0], m[1], 0, b % 3, (b + m) % 4, m, 2);
                xfer_len = 4'((b + m) % 3);
                run_pair(b % 4, (b + m) % 4, m[0]);
            end
        end

        // R8 / R9: exact hold-off with the request held
        setcfg(0, 0, 0, 0, 0, 0, 5, 9);
        xfer_len = 4'd0;
        run_pair(1, 1, 1);
        run_pair(0, 2, 1);
        setcfg(0, 1, 0, 0, 0, 0, 7, 2);
        run_pair(3, 0, 1);

        // R7: encoded select for an external decoder
        setcfg(2, 1, 1, 1, 1, 1, 3, 6);
        xfer_len = 4'd1;
        run_pair(10, 10, 1);
        run_pair(10, 5, 1);

        // R3 / R4 at large guards
        setcfg(3, 0, 1, 0, 255, 200, 0, 0);
        xfer_len = 4'd2;
        run_pair(2, 2, 0);

        report();
    end

endmodule